// File: doc/BRIEF.md
# Codec Byte-Stream FIFO Port

This block sits between a host bus and a serial audio codec. A host write pushes the low byte of a 16-bit data word into a transmit queue, and a host read takes the oldest received byte from a receive queue. The codec side moves one byte in each direction every time the external byte-rate strobe fires. The transmit byte goes out most significant bit first on a serial line, with a one-cycle frame pulse at the start. At the same time the receive byte is shifted in from the codec.

The port works only while the serial-routing select input chooses the codec. Turning the select off empties both queues, stops any transfer in progress and restarts the transfer count. A repeating interrupt fires after every eighth completed byte, whatever the queue levels are. It sets a sticky pending flag, which the host clears with an acknowledge strobe. At the usual 8 kbyte/s byte rate this gives a 1 kHz interrupt.

The transfer engine is a three-state machine:
- `ENG_IDLE` waits for a byte strobe. On a strobe it loads the transmit shifter and raises the frame pulse (transition *start*).
- `ENG_SHIFT` runs for eight clocks. It shifts one bit out and one bit in on each clock (transition *last bit*, to the next state).
- `ENG_COMMIT` stores the received byte, advances the byte count and returns to `ENG_IDLE` (transition *commit*).

Any state goes back to `ENG_IDLE` when the select is off (transition *abort*).

Top module: `codec_fifo_if`

## Requirements
- R1: While `codec_sel` is 1, a `host_wr` pulse pushes `host_wdata[7:0]` into the transmit queue and ignores `host_wdata[15:8]`. A write while the queue is full is dropped.
- R2: `host_rdata` is `{8'h00, oldest receive byte}` when the receive queue holds data, and 16'h0000 when it is empty. A `host_rd` pulse removes that byte. A read of an empty queue changes nothing.
- R3: Each queue holds 16 bytes. The full flag is set after 16 pushes, and a 17th push has no effect.
- R4: The `fifo_status` bits are: bit 0 transmit empty, bit 1 transmit full, bit 2 receive empty, bit 3 receive full. After reset the value is 4'b0101.
- R5: A `byte_tick` seen in `ENG_IDLE` with the select on does three things:
  - it raises `codec_frame` for exactly the next cycle;
  - it drives `codec_sdo` for the next 8 cycles with the oldest transmit byte, MSB first, removing that byte from the queue;
  - it sends 0x00 instead when the transmit queue is empty.
  `codec_sdo` is 0 outside those 8 cycles.
- R6: `codec_sdi` is sampled on the 8 clock edges that follow the frame cycle, MSB first. The byte is pushed into the receive queue one clock later. It is dropped if that queue is full.
- R7: `codec_irq` is a one-cycle pulse that fires on the commit of every 8th completed byte after enable or reset.
- R8: `codec_irq_pend` rises with `codec_irq` and stays set until an `irq_ack` cycle with no new pulse. A new pulse wins over a simultaneous acknowledge.
- R9: While `codec_sel` is 0, both queues are empty, the byte count is zero, and strobes and writes have no effect.
- R10: A `byte_tick` that arrives while a transfer is in progress is ignored and does not start a second frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| codec_sel | input | 1 | Routes the serial port to the codec and enables the block |
| host_wr | input | 1 | Host write strobe (push) |
| host_wdata | input | 16 | Host write data; only bits 7:0 are used |
| host_rd | input | 1 | Host read strobe (pop) |
| host_rdata | output | 16 | Oldest received byte, upper byte zero |
| irq_ack | input | 1 | Clears the pending interrupt flag |
| byte_tick | input | 1 | Byte-rate strobe from the codec clock generator |
| codec_sdi | input | 1 | Serial data from the codec |
| codec_sdo | output | 1 | Serial data to the codec |
| codec_frame | output | 1 | One-cycle pulse that marks the start of a byte |
| codec_irq | output | 1 | Periodic interrupt pulse |
| codec_irq_pend | output | 1 | Sticky interrupt pending flag |
| fifo_status | output | 4 | {rx_full, rx_empty, tx_full, tx_empty} |

## Verification
The bench builds the block with its default parameters:
- a 16-byte queue depth and a period of 8 bytes per interrupt;
- a transmit queue that can be filled past capacity with a handful of writes;
- twenty strobes, enough to overrun the receive queue, to run past the end of the transmit data into zero bytes, and to cover two full interrupt periods.

With these values, disabling part-way through a period shows that the count restarts. Strobes placed inside a running transfer exercise the ignore rule.

// File: rtl/codec_pkg.sv
package codec_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_SHIFT  = 2'd1,
        ENG_COMMIT = 2'd2
    } eng_state_t;

endpackage

// File: rtl/codec_sync_fifo.sv
module codec_sync_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CAP);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = store[rptr];

    always_ff @(posedge clk) begin
        if (do_push) store[wptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3: occupancy never passes capacity
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CAP);

    // R3: a push into a full queue without a pop leaves it full
    a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);

endmodule

// File: rtl/codec_serial_engine.sv
module codec_serial_engine
    import codec_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         byte_tick,
    input  logic         tx_empty,
    input  logic [W-1:0] tx_head,
    input  logic         rx_full,
    input  logic         sdi,
    output logic         tx_pop,
    output logic         rx_push,
    output logic [W-1:0] rx_byte,
    output logic         byte_done,
    output logic         sdo,
    output logic         frame
);
    localparam int BW = (W > 1) ? $clog2(W) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

    eng_state_t     state, state_nx;
    logic [BW-1:0]  bit_cnt;
    logic [W-1:0]   tx_sh, rx_sh;
    logic           frame_q;
    logic           start;

    assign start = (state == ENG_IDLE) && enable && byte_tick;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ENG_IDLE:   if (start) state_nx = ENG_SHIFT;
            ENG_SHIFT:  if (bit_cnt == LAST_BIT) state_nx = ENG_COMMIT;
            ENG_COMMIT: state_nx = ENG_IDLE;
            default:    state_nx = ENG_IDLE;
        endcase
        if (!enable) state_nx = ENG_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            frame_q <= 1'b0;
        end else begin
            frame_q <= start;
            if (start) begin
                tx_sh   <= tx_empty ? '0 : tx_head;
                bit_cnt <= '0;
            end else if (state == ENG_SHIFT && enable) begin
                tx_sh   <= {tx_sh[W-2:0], 1'b0};
                rx_sh   <= {rx_sh[W-2:0], sdi};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        tx_pop    = start && !tx_empty;
        byte_done = (state == ENG_COMMIT) && enable;
        rx_push   = byte_done && !rx_full;
        rx_byte   = rx_sh;
        sdo       = (state == ENG_SHIFT) ? tx_sh[W-1] : 1'b0;
        frame     = frame_q;
    end

    // R5: frame lasts one cycle
    a_r5_frame_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame |=> !frame);

    // R5: the cycle after a frame pulse is a shifting cycle
    a_r5_frame_then_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (frame && enable) |-> (state == ENG_SHIFT));

    // R10: a strobe during shifting does not restart the frame
    a_r10_tick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_SHIFT && byte_tick) |=> !frame);

    // R6: a commit is always preceded by shifting
    a_r6_commit_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_COMMIT) |-> ($past(state) == ENG_SHIFT));

endmodule

// File: rtl/codec_irq_gen.sv
module codec_irq_gen #(
    parameter int BYTES_PER_IRQ = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic byte_done,
    input  logic ack,
    output logic irq_pulse,
    output logic irq_pend
);
    localparam int CW = (BYTES_PER_IRQ > 1) ? $clog2(BYTES_PER_IRQ) : 1;
    localparam logic [CW-1:0] WRAP = CW'(BYTES_PER_IRQ - 1);

    logic [CW-1:0] cnt;
    logic          fire;

    assign fire = byte_done && (cnt == WRAP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            irq_pulse <= 1'b0;
            irq_pend  <= 1'b0;
        end else begin
            irq_pulse <= fire;
            if (fire)     irq_pend <= 1'b1;
            else if (ack) irq_pend <= 1'b0;
            if (!enable)        cnt <= '0;
            else if (fire)      cnt <= '0;
            else if (byte_done) cnt <= cnt + 1'b1;
        end
    end

    // R7: interrupt is a single-cycle pulse
    a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R8: pending is set whenever a pulse is present
    a_r8_pend_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> irq_pend);

    // R8: acknowledge with no completing byte clears pending
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !byte_done) |=> !irq_pend);

    // R9: count is zero after a disabled cycle, so no pulse right after
    a_r9_no_fire_after_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !irq_pulse);

endmodule

// File: rtl/codec_fifo_if.sv
module codec_fifo_if
    import codec_pkg::*;
#(
    parameter int HOST_W        = 16,
    parameter int BYTE_W        = 8,
    parameter int FIFO_DEPTH    = 16,
    parameter int BYTES_PER_IRQ = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              codec_sel,
    input  logic              host_wr,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [HOST_W-1:0] host_rdata,
    input  logic              irq_ack,
    input  logic              byte_tick,
    input  logic              codec_sdi,
    output logic              codec_sdo,
    output logic              codec_frame,
    output logic              codec_irq,
    output logic              codec_irq_pend,
    output logic [3:0]        fifo_status
);
    localparam int PAD_W = HOST_W - BYTE_W;

    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic              tx_pop, rx_push, byte_done;
    logic [BYTE_W-1:0] tx_head, rx_head, rx_byte;
    logic              flush;

    assign flush = !codec_sel;

    codec_sync_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (host_wr && codec_sel),
        .push_data (host_wdata[BYTE_W-1:0]),
        .pop       (tx_pop),
        .head      (tx_head),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    codec_sync_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (rx_push),
        .push_data (rx_byte),
        .pop       (host_rd && codec_sel),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    codec_serial_engine #(.W(BYTE_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (codec_sel),
        .byte_tick (byte_tick),
        .tx_empty  (tx_empty),
        .tx_head   (tx_head),
        .rx_full   (rx_full),
        .sdi       (codec_sdi),
        .tx_pop    (tx_pop),
        .rx_push   (rx_push),
        .rx_byte   (rx_byte),
        .byte_done (byte_done),
        .sdo       (codec_sdo),
        .frame     (codec_frame)
    );

    codec_irq_gen #(.BYTES_PER_IRQ(BYTES_PER_IRQ)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (codec_sel),
        .byte_done (byte_done),
        .ack       (irq_ack),
        .irq_pulse (codec_irq),
        .irq_pend  (codec_irq_pend)
    );

    always_comb begin
        host_rdata  = (codec_sel && !rx_empty) ? {{PAD_W{1'b0}}, rx_head} : '0;
        fifo_status = {rx_full, rx_empty, tx_full, tx_empty};
    end

    // R9: deselecting empties both queues
    a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !codec_sel |=> (fifo_status[0] && fifo_status[2]));

    // R2: the upper half of the read word is always zero
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[HOST_W-1:BYTE_W] == '0);

    // R1: an accepted write makes the transmit queue non-empty
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && codec_sel && tx_empty) |=> !fifo_status[0]);

    // R1: upper write bits never reach the serial line during deselect
    a_r1_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!codec_sel && host_wdata[HOST_W-1]) |=> !codec_sdo);

endmodule

// File: tb/codec_fifo_if_test.sv
module codec_fifo_if_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        codec_sel = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic        host_rd = 1'b0;
    logic [15:0] host_rdata;
    logic        irq_ack = 1'b0;
    logic        byte_tick = 1'b0;
    logic        codec_sdi = 1'b0;
    logic        codec_sdo, codec_frame, codec_irq, codec_irq_pend;
    logic [3:0]  fifo_status;

    always #2 clk = ~clk;

    codec_fifo_if uut (
        .clk(clk), .rst_n(rst_n), .codec_sel(codec_sel),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .irq_ack(irq_ack), .byte_tick(byte_tick),
        .codec_sdi(codec_sdi), .codec_sdo(codec_sdo), .codec_frame(codec_frame),
        .codec_irq(codec_irq), .codec_irq_pend(codec_irq_pend),
        .fifo_status(fifo_status)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int frames = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // reference model state
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    int         phase = 0;
    logic [7:0] m_tx = 0, m_rx = 0;
    int         m_cnt = 0;
    bit         m_frame = 0, m_irq = 0, m_pend = 0;

    always @(posedge clk) begin
        int pre_tx, pre_rx;
        bit commit;
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            phase = 0; m_cnt = 0; m_frame = 0; m_irq = 0; m_pend = 0;
        end else begin
            m_irq = 0; m_frame = 0; commit = 0;
            pre_tx = txq.size(); pre_rx = rxq.size();
            if (!codec_sel) begin
                txq.delete(); rxq.delete();
                phase = 0; m_cnt = 0;
            end else begin
                if (phase == 0) begin
                    if (byte_tick) begin
                        m_tx = (pre_tx > 0) ? txq.pop_front() : 8'h00;
                        m_frame = 1; phase = 1;
                    end
                end else if (phase <= 8) begin
                    m_rx = {m_rx[6:0], codec_sdi};
                    m_tx = {m_tx[6:0], 1'b0};
                    phase++;
                end else begin
                    commit = 1; phase = 0;
                    m_cnt = (m_cnt + 1) % 8;
                    if (m_cnt == 0) begin m_irq = 1; end
                end
                if (host_wr && pre_tx < 16) txq.push_back(host_wdata[7:0]);
                if (host_rd && pre_rx > 0) void'(rxq.pop_front());
                if (commit && pre_rx < 16) rxq.push_back(m_rx);
            end
            if (m_irq) m_pend = 1;
            else if (irq_ack) m_pend = 0;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(posedge clk) begin
        logic [3:0]  e_st;
        logic [15:0] e_rd;
        bit          e_sdo;
        #1;
        cycles++;
        if (codec_frame) frames++;
        e_st = {rxq.size() == 16, rxq.size() == 0, txq.size() == 16, txq.size() == 0};
        e_rd = (rxq.size() > 0) ? {8'h00, rxq[0]} : 16'h0000;
        e_sdo = (phase >= 1 && phase <= 8) ? m_tx[7] : 1'b0;
        chk(fifo_status == e_st, "R4 status", 32'(fifo_status), 32'(e_st));
        chk(host_rdata == e_rd, "R2 rdata", 32'(host_rdata), 32'(e_rd));
        chk(codec_sdo == e_sdo, "R5 sdo", 32'(codec_sdo), 32'(e_sdo));
        chk(codec_frame == m_frame, "R5 frame", 32'(codec_frame), 32'(m_frame));
        chk(codec_irq == m_irq, "R7 irq", 32'(codec_irq), 32'(m_irq));
        chk(codec_irq_pend == m_pend, "R8 pend", 32'(codec_irq_pend), 32'(m_pend));
        if (cycles == 150000 && !done) begin
            chk(0, "watchdog", 32'(cycles), 0);
            finish_run();
        end
    end

    // serial input pattern
    logic [7:0] lfsr = 8'hA5;
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        codec_sdi <= lfsr[0];
    end

    task automatic write_byte(input logic [15:0] d);
        @(negedge clk); host_wr = 1; host_wdata = d;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic one_byte(input bit mid_tick);
        @(negedge clk); byte_tick = 1;
        @(negedge clk); byte_tick = 0;
        repeat (3) @(negedge clk);
        if (mid_tick) begin byte_tick = 1; @(negedge clk); byte_tick = 0; end
        repeat (9) @(negedge clk);
    endtask

    task automatic ack_irq();
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
    endtask

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        chk(fifo_status == 4'b0101, "R4 reset", 32'(fifo_status), 32'h5);
        rst_n = 1;
        @(negedge clk); codec_sel = 1;
        // R1: upper byte ignored, low byte pushed
        write_byte(16'hFFA0);
        @(negedge clk);
        chk(fifo_status[0] == 0, "R1 push", 32'(fifo_status), 32'h4);
        for (int i = 1; i < 17; i++) write_byte(16'(16'h1200 + 16'hA0 + i));
        @(negedge clk);
        chk(fifo_status[1] == 1, "R3 tx full", 32'(fifo_status), 32'h6);
        // 20 transfers: drains tx, then sends zeros, overfills rx
        f0 = frames;
        for (int i = 0; i < 20; i++) begin
            one_byte(i == 2 || i == 11);   // R10 strobes inside transfers
            if (i == 7) begin
                chk(codec_irq_pend == 1, "R8 pend set", 32'(codec_irq_pend), 1);
                ack_irq();
                @(negedge clk);
                chk(codec_irq_pend == 0, "R8 ack", 32'(codec_irq_pend), 0);
            end
        end
        chk(frames - f0 == 20, "R10 frames", 32'(frames - f0), 32'd20);
        chk(fifo_status[3] == 1, "R6 rx full", 32'(fifo_status), 32'h9);
        chk(fifo_status[0] == 1, "R5 tx drained", 32'(fifo_status), 32'h9);
        // drain rx through reads (model checks every value)
        for (int i = 0; i < 18; i++) begin
            @(negedge clk); host_rd = 1;
            @(negedge clk); host_rd = 0;
        end
        chk(fifo_status[2] == 1, "R2 rx drained", 32'(fifo_status), 32'h5);
        ack_irq();
        // R9: partial period, disable, re-enable
        write_byte(16'h003C);
        for (int i = 0; i < 3; i++) one_byte(0);
        write_byte(16'h0077);
        @(negedge clk); codec_sel = 0;
        @(negedge clk);
        chk(fifo_status == 4'b0101, "R9 flush", 32'(fifo_status), 32'h5);
        f0 = frames;
        one_byte(0);
        write_byte(16'h0055);
        chk(frames == f0, "R9 tick off", 32'(frames), 32'(f0));
        chk(fifo_status[0] == 1, "R9 write off", 32'(fifo_status), 32'h5);
        @(negedge clk); codec_sel = 1;
        for (int i = 0; i < 7; i++) one_byte(0);
        chk(codec_irq_pend == 0, "R9 count reset", 32'(codec_irq_pend), 0);
        one_byte(0);
        chk(codec_irq_pend == 1, "R7 eighth byte", 32'(codec_irq_pend), 1);
        repeat (4) @(negedge clk);
        done = 1;
        finish_run();
    end

endmodule